// File: doc/BRIEF.md
# Four-Mode Power State Controller

This block sequences the clock and power controls of a small system-on-chip through four operating modes: normal, slow, idle and sleep. Software selects a mode through a mode-request register and chooses which peripherals receive a clock through a clock-enable register, both written over a simple synchronous register bus. From the current mode the block drives registered, glitch-free enables: a CPU clock enable, a select between the PLL and the external reference clock, a PLL power-down, a per-peripheral clock-enable vector, a separately controlled USB clock enable, a switch for the core power domain and a reset for the core logic.

Idle stops only the CPU clock and returns to the mode it came from when the CPU interrupt request rises. Sleep turns the core domain off. Only the wake-up logic, on its own always-on supply, keeps running, and only an external interrupt line or the RTC alarm ends sleep. On the way out of sleep the core power comes back first. The core is then held in reset for a programmable number of reference clock cycles before clocks return in normal mode. A wake-source register records which event ended sleep. All logic runs on the reference clock, and every asynchronous wake input passes through a two-stage synchronizer.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the block is in normal mode with the control vector {cpu_clk_en, clk_src_ext, pll_pdn, usb_clk_en, core_pwr_on, core_rst_n} = 1,0,0,1,1,1 and all peripheral enables at 1. The registers read: address 0 (mode) = 0, address 1 (clock enables) = all ones, address 2 (wake source) = 0, address 3 (config) = 0x8000_0004.
- R2: In normal, slow and idle mode, periph_clk_en equals the clock-enable register (address 1, bit i = peripheral i). The output follows a write at the second rising edge after the write is sampled.
- R3: Writing mode code 1 to address 0 bits [1:0] enters slow mode at the sampling edge: cpu_clk_en=1, clk_src_ext=1, pll_pdn=1. Code 0 returns to normal mode: clk_src_ext=0, pll_pdn=0.
- R4: Code 2 enters idle mode at the sampling edge: cpu_clk_en=0. The clock source, the PLL power-down and all peripheral and USB enables keep the values of the mode it left.
- R5: Idle mode ends only on cpu_irq. The request is synchronized through two flops, so the block is back in its previous mode (normal or slow) at the third rising edge after cpu_irq rises. External lines and the RTC alarm do not end idle.
- R6: Code 3 enters sleep at the sampling edge: core_pwr_on=0, core_rst_n=0, cpu_clk_en=0, usb_clk_en=0, periph_clk_en all 0, pll_pdn=1, clk_src_ext=1.
- R7: Sleep ends only on a rising ext_irq line or rtc_alarm, at the third rising edge after the input rises. cpu_irq has no effect during sleep.
- R8: At the wake edge core_pwr_on=1 while core_rst_n=0, cpu_clk_en=0, clk_src_ext=1, pll_pdn=0 and the peripheral and USB enables are 0. After hold+1 further edges (hold = address 3 bits [15:0]) the block is in normal mode with the R1 control values.
- R9: Address 2 reads the wake-source record: bit i = ext_irq[i], bit 16 = rtc_alarm. The bits that were high at the wake event are set. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R10: Mode requests are accepted only in normal or slow mode. A request made in idle, sleep or the wake sequence is ignored.
- R11: usb_clk_en follows address 3 bit 31 outside sleep and the wake sequence, at the second edge after the write, whatever the mode.
- R12: Address 0 reads the current mode code: 0 normal, 1 slow, 2 idle, 3 sleep, 4 waking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, always running |
| rst_n | input | 1 | Asynchronous active-low reset of the always-on logic |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| cpu_irq | input | 1 | CPU interrupt request, ends idle |
| ext_irq | input | 16 | External interrupt lines, end sleep |
| rtc_alarm | input | 1 | RTC alarm, ends sleep |
| cpu_clk_en | output | 1 | CPU core clock enable |
| clk_src_ext | output | 1 | 1 selects the external reference as CPU/bus clock, 0 selects the PLL |
| pll_pdn | output | 1 | Main PLL power-down |
| periph_clk_en | output | 8 | Per-peripheral clock enables |
| usb_clk_en | output | 1 | USB clock enable from the second PLL |
| core_pwr_on | output | 1 | Core power-domain switch |
| core_rst_n | output | 1 | Core logic reset, active low |

## Verification
Mode requests are applied in every source mode, both accepted and refused, so that a lost request can be told apart from a request taken in the wrong mode. Wake stimulus is crossed with the mode: cpu_irq during sleep, and external lines during idle, must leave the mode unchanged, while the matching source must end it at the exact synchronized edge. Sleep exits use different external lines, the RTC and several reset hold counts, so that an off-by-one in the hold window and a wrong wake-source bit both show. Random clock-enable writes interleaved with normal, slow and idle transitions show whether the peripheral vector and the clock source follow the model together.

// File: rtl/pm_pkg.sv
package pm_pkg;

  typedef enum logic [2:0] {
    PM_NORMAL = 3'd0,
    PM_SLOW   = 3'd1,
    PM_IDLE   = 3'd2,
    PM_SLEEP  = 3'd3,
    PM_WAKE   = 3'd4
  } pm_state_e;

  localparam logic [1:0] A_MODE  = 2'd0;
  localparam logic [1:0] A_CLKEN = 2'd1;
  localparam logic [1:0] A_WSRC  = 2'd2;
  localparam logic [1:0] A_CFG   = 2'd3;

  typedef struct packed {
    logic cpu_en;
    logic src_ext;
    logic pll_pdn;
    logic usb_en;
    logic pwr_on;
    logic rst_n;
  } pm_ctl_t;

  // control vector of one state; ret_slow tells idle which source to keep
  function automatic pm_ctl_t pm_decode(pm_state_e st, logic ret_slow, logic usb_cfg);
    pm_ctl_t c;
    c = '{cpu_en: 1'b1, src_ext: 1'b0, pll_pdn: 1'b0, usb_en: usb_cfg,
          pwr_on: 1'b1, rst_n: 1'b1};
    case (st)
      PM_SLOW:  begin c.src_ext = 1'b1; c.pll_pdn = 1'b1; end
      PM_IDLE:  begin c.cpu_en = 1'b0; c.src_ext = ret_slow; c.pll_pdn = ret_slow; end
      PM_SLEEP: c = '{cpu_en: 1'b0, src_ext: 1'b1, pll_pdn: 1'b1, usb_en: 1'b0,
                      pwr_on: 1'b0, rst_n: 1'b0};
      PM_WAKE:  c = '{cpu_en: 1'b0, src_ext: 1'b1, pll_pdn: 1'b0, usb_en: 1'b0,
                      pwr_on: 1'b1, rst_n: 1'b0};
      default: ;
    endcase
    return c;
  endfunction

  // peripheral clocks run whenever the core domain is up and out of reset
  function automatic logic pm_periph_on(pm_state_e st);
    return (st == PM_NORMAL) || (st == PM_SLOW) || (st == PM_IDLE);
  endfunction

  function automatic logic pm_req_ok(pm_state_e st);
    return (st == PM_NORMAL) || (st == PM_SLOW);
  endfunction

endpackage

// File: rtl/pm_sync.sv
module pm_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/pm_regs.sv
module pm_regs
  import pm_pkg::*;
#(
  parameter int N_PERIPH = 8,
  parameter int N_EXT    = 16,
  parameter int HOLD_W   = 16,
  parameter int BUS_W    = 32,
  parameter int HOLD_RST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  pm_state_e         state_q,
  input  logic              src_set,
  input  logic [N_EXT:0]    src_vec,
  output logic              req_valid,
  output logic [1:0]        req_mode,
  output logic [N_PERIPH-1:0] clk_en_q,
  output logic              usb_cfg_q,
  output logic [HOLD_W-1:0] hold_cfg_q,
  output logic [N_EXT:0]    wake_src_q
);
  localparam int SRC_W = N_EXT + 1;

  logic wr_clken, wr_wsrc, wr_cfg;
  logic [SRC_W-1:0] clr_vec;

  assign req_valid = bus_wr && (bus_addr == A_MODE);
  assign req_mode  = bus_wdata[1:0];
  assign wr_clken  = bus_wr && (bus_addr == A_CLKEN);
  assign wr_wsrc   = bus_wr && (bus_addr == A_WSRC);
  assign wr_cfg    = bus_wr && (bus_addr == A_CFG);
  assign clr_vec   = wr_wsrc ? bus_wdata[SRC_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_en_q   <= '1;
      usb_cfg_q  <= 1'b1;
      hold_cfg_q <= HOLD_W'(HOLD_RST);
      wake_src_q <= '0;
    end else begin
      if (wr_clken) clk_en_q <= bus_wdata[N_PERIPH-1:0];
      if (wr_cfg) begin
        usb_cfg_q  <= bus_wdata[BUS_W-1];
        hold_cfg_q <= bus_wdata[HOLD_W-1:0];
      end
      // a new wake event wins over a clear in the same cycle
      wake_src_q <= (wake_src_q & ~clr_vec) | (src_set ? src_vec : '0);
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_MODE:  bus_rdata[2:0]          = state_q;
      A_CLKEN: bus_rdata[N_PERIPH-1:0] = clk_en_q;
      A_WSRC:  bus_rdata[SRC_W-1:0]    = wake_src_q;
      default: begin
        bus_rdata[HOLD_W-1:0] = hold_cfg_q;
        bus_rdata[BUS_W-1]    = usb_cfg_q;
      end
    endcase
  end
endmodule

// File: rtl/pm_fsm.sv
module pm_fsm
  import pm_pkg::*;
#(
  parameter int N_EXT  = 16,
  parameter int HOLD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_mode,
  input  logic              irq_s,
  input  logic [N_EXT-1:0]  ext_s,
  input  logic              rtc_s,
  input  logic [HOLD_W-1:0] hold_cfg,
  output pm_state_e         state_q,
  output pm_state_e         state_d,
  output logic              ret_slow_d,
  output logic              req_accept,
  output logic              idle_wake,
  output logic              sleep_wake,
  output logic              hold_done
);
  logic              ret_slow_q;
  logic [HOLD_W-1:0] cnt_q, cnt_d;

  assign req_accept = req_valid && pm_req_ok(state_q);
  assign idle_wake  = (state_q == PM_IDLE) && irq_s;
  assign sleep_wake = (state_q == PM_SLEEP) && ((|ext_s) || rtc_s);
  assign hold_done  = (state_q == PM_WAKE) && (cnt_q == '0);

  always_comb begin
    state_d    = state_q;
    ret_slow_d = ret_slow_q;
    cnt_d      = cnt_q;
    case (state_q)
      PM_NORMAL, PM_SLOW: begin
        if (req_accept) begin
          state_d = pm_state_e'({1'b0, req_mode});
          if (req_mode == 2'd2) ret_slow_d = (state_q == PM_SLOW);
        end
      end
      PM_IDLE: if (idle_wake) state_d = ret_slow_q ? PM_SLOW : PM_NORMAL;
      PM_SLEEP: if (sleep_wake) begin
        state_d = PM_WAKE;
        cnt_d   = hold_cfg;
      end
      PM_WAKE: begin
        if (hold_done) begin
          state_d    = PM_NORMAL;
          ret_slow_d = 1'b0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = PM_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= PM_NORMAL;
      ret_slow_q <= 1'b0;
      cnt_q      <= '0;
    end else begin
      state_q    <= state_d;
      ret_slow_q <= ret_slow_d;
      cnt_q      <= cnt_d;
    end
  end
endmodule

// File: rtl/pm_outreg.sv
module pm_outreg
  import pm_pkg::*;
#(
  parameter int N_PERIPH = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  pm_state_e           state_d,
  input  logic                ret_slow_d,
  input  logic [N_PERIPH-1:0] clk_en_q,
  input  logic                usb_cfg_q,
  output logic                cpu_clk_en,
  output logic                clk_src_ext,
  output logic                pll_pdn,
  output logic [N_PERIPH-1:0] periph_clk_en,
  output logic                usb_clk_en,
  output logic                core_pwr_on,
  output logic                core_rst_n
);
  pm_ctl_t ctl_d;
  logic    per_on_d;

  assign ctl_d    = pm_decode(state_d, ret_slow_d, usb_cfg_q);
  assign per_on_d = pm_periph_on(state_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_clk_en  <= 1'b1;
      clk_src_ext <= 1'b0;
      pll_pdn     <= 1'b0;
      usb_clk_en  <= 1'b1;
      core_pwr_on <= 1'b1;
      core_rst_n  <= 1'b1;
    end else begin
      cpu_clk_en  <= ctl_d.cpu_en;
      clk_src_ext <= ctl_d.src_ext;
      pll_pdn     <= ctl_d.pll_pdn;
      usb_clk_en  <= ctl_d.usb_en;
      core_pwr_on <= ctl_d.pwr_on;
      core_rst_n  <= ctl_d.rst_n;
    end
  end

  for (genvar i = 0; i < N_PERIPH; i++) begin : g_per
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) periph_clk_en[i] <= 1'b1;
      else        periph_clk_en[i] <= per_on_d && clk_en_q[i];
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pm_pkg::*;
#(
  parameter int N_PERIPH = 8,
  parameter int N_EXT    = 16,
  parameter int HOLD_W   = 16,
  parameter int BUS_W    = 32,
  parameter int HOLD_RST = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [1:0]          bus_addr,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  input  logic                cpu_irq,
  input  logic [N_EXT-1:0]    ext_irq,
  input  logic                rtc_alarm,
  output logic                cpu_clk_en,
  output logic                clk_src_ext,
  output logic                pll_pdn,
  output logic [N_PERIPH-1:0] periph_clk_en,
  output logic                usb_clk_en,
  output logic                core_pwr_on,
  output logic                core_rst_n
);
  localparam int SYNC_W = N_EXT + 2;

  logic [SYNC_W-1:0]   sync_q;
  logic                irq_s, rtc_s;
  logic [N_EXT-1:0]    ext_s;
  logic                req_valid, req_accept, idle_wake, sleep_wake, hold_done;
  logic [1:0]          req_mode;
  logic [N_PERIPH-1:0] clk_en_q;
  logic                usb_cfg_q, ret_slow_d;
  logic [HOLD_W-1:0]   hold_cfg_q;
  logic [N_EXT:0]      wake_src_q;
  pm_state_e           state_q, state_d;

  pm_sync #(.W(SYNC_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cpu_irq, rtc_alarm, ext_irq}), .q(sync_q));

  assign irq_s = sync_q[SYNC_W-1];
  assign rtc_s = sync_q[N_EXT];
  assign ext_s = sync_q[N_EXT-1:0];

  pm_regs #(.N_PERIPH(N_PERIPH), .N_EXT(N_EXT), .HOLD_W(HOLD_W),
            .BUS_W(BUS_W), .HOLD_RST(HOLD_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .state_q(state_q),
    .src_set(sleep_wake), .src_vec({rtc_s, ext_s}),
    .req_valid(req_valid), .req_mode(req_mode), .clk_en_q(clk_en_q),
    .usb_cfg_q(usb_cfg_q), .hold_cfg_q(hold_cfg_q), .wake_src_q(wake_src_q));

  pm_fsm #(.N_EXT(N_EXT), .HOLD_W(HOLD_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .irq_s(irq_s), .ext_s(ext_s), .rtc_s(rtc_s), .hold_cfg(hold_cfg_q),
    .state_q(state_q), .state_d(state_d), .ret_slow_d(ret_slow_d),
    .req_accept(req_accept), .idle_wake(idle_wake), .sleep_wake(sleep_wake),
    .hold_done(hold_done));

  pm_outreg #(.N_PERIPH(N_PERIPH)) u_out (
    .clk(clk), .rst_n(rst_n), .state_d(state_d), .ret_slow_d(ret_slow_d),
    .clk_en_q(clk_en_q), .usb_cfg_q(usb_cfg_q), .cpu_clk_en(cpu_clk_en),
    .clk_src_ext(clk_src_ext), .pll_pdn(pll_pdn), .periph_clk_en(periph_clk_en),
    .usb_clk_en(usb_clk_en), .core_pwr_on(core_pwr_on), .core_rst_n(core_rst_n));
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk
  import pm_pkg::*;
#(
  parameter int N_PERIPH = 8
) (
  input logic                clk,
  input logic                rst_n,
  input pm_state_e           state_q,
  input logic                req_accept,
  input logic                idle_wake,
  input logic                sleep_wake,
  input logic                hold_done,
  input logic                cpu_clk_en,
  input logic                clk_src_ext,
  input logic                pll_pdn,
  input logic [N_PERIPH-1:0] periph_clk_en,
  input logic                usb_clk_en,
  input logic                core_pwr_on,
  input logic                core_rst_n
);
  p_sleep_gates_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !core_pwr_on |-> (!cpu_clk_en && periph_clk_en == '0 && !usb_clk_en && !core_rst_n && pll_pdn));

  p_slow_pll_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_src_ext && cpu_clk_en) |-> pll_pdn);

  p_idle_stays_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_IDLE && !idle_wake) |=> (state_q == PM_IDLE && !cpu_clk_en));

  p_idle_returns_r5: assert property (@(posedge clk) disable iff (!rst_n)
    idle_wake |=> ((state_q == PM_NORMAL || state_q == PM_SLOW) && cpu_clk_en));

  p_sleep_stays_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_SLEEP && !sleep_wake) |=> (state_q == PM_SLEEP && !core_pwr_on));

  p_wake_power_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_wake |=> (core_pwr_on && !core_rst_n));

  p_rst_after_pwr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst_n) |-> $past(core_pwr_on));

  p_hold_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_done |=> (state_q == PM_NORMAL && core_rst_n && cpu_clk_en && !clk_src_ext));

  p_req_mode_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |-> (state_q == PM_NORMAL || state_q == PM_SLOW));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.N_PERIPH(N_PERIPH)) u_chk (
  .clk(clk), .rst_n(rst_n), .state_q(state_q), .req_accept(req_accept),
  .idle_wake(idle_wake), .sleep_wake(sleep_wake), .hold_done(hold_done),
  .cpu_clk_en(cpu_clk_en), .clk_src_ext(clk_src_ext), .pll_pdn(pll_pdn),
  .periph_clk_en(periph_clk_en), .usb_clk_en(usb_clk_en),
  .core_pwr_on(core_pwr_on), .core_rst_n(core_rst_n));

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cpu_irq = 1'b0;
  logic [15:0] ext_irq = '0;
  logic        rtc_alarm = 1'b0;
  logic        cpu_clk_en, clk_src_ext, pll_pdn, usb_clk_en, core_pwr_on, core_rst_n;
  logic [7:0]  periph_clk_en;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model
  int       m_mode = 0;
  bit       m_rs = 1'b0;
  bit [7:0] m_ce = 8'hFF;
  bit       m_usb = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_irq(cpu_irq),
    .ext_irq(ext_irq), .rtc_alarm(rtc_alarm), .cpu_clk_en(cpu_clk_en),
    .clk_src_ext(clk_src_ext), .pll_pdn(pll_pdn), .periph_clk_en(periph_clk_en),
    .usb_clk_en(usb_clk_en), .core_pwr_on(core_pwr_on), .core_rst_n(core_rst_n));

  // expected {cpu, src_ext, pll_pdn, usb, pwr, rst_n, periph}
  function automatic logic [13:0] exp_vec(int m, bit rs, bit [7:0] ce, bit usb);
    case (m)
      0:       return {1'b1, 1'b0, 1'b0, usb, 1'b1, 1'b1, ce};
      1:       return {1'b1, 1'b1, 1'b1, usb, 1'b1, 1'b1, ce};
      2:       return {1'b0, rs, rs, usb, 1'b1, 1'b1, ce};
      3:       return {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00};
      default: return {1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00};
    endcase
  endfunction

  function automatic logic [13:0] act_vec();
    return {cpu_clk_en, clk_src_ext, pll_pdn, usb_clk_en, core_pwr_on, core_rst_n, periph_clk_en};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_vec(input string tag, input int m);
    logic [13:0] e;
    e = exp_vec(m, m_rs, m_ce, m_usb);
    chk(act_vec() === e, tag, {18'd0, act_vec()}, {18'd0, e});
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] e, input string tag);
    bus_addr = a;
    #1;
    chk(bus_rdata === e, tag, bus_rdata, e);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  // request a mode; the model follows only when the request is legal
  task automatic req(input int m);
    wr(2'd0, 32'(m));
    if (m_mode == 0 || m_mode == 1) begin
      if (m == 2) m_rs = (m_mode == 1);
      m_mode = m;
    end
  endtask

  task automatic idle_exit(input string tag);
    @(negedge clk); cpu_irq = 1'b1;
    wait_neg(2);
    chk(!cpu_clk_en, {tag, " still idle before sync"}, {31'd0, cpu_clk_en}, 32'd0);
    wait_neg(1);
    m_mode = m_rs ? 1 : 0;
    chk_vec({tag, " back from idle"}, m_mode);
    cpu_irq = 1'b0;
    wait_neg(3);
  endtask

  // sleep exit through the chosen source, bit 16 = RTC
  task automatic sleep_cycle(input int src, input int hold);
    wr(2'd3, {m_usb, 15'd0, 16'(hold)});
    req(3);
    chk_vec("R6 sleep outputs", 3);
    rd_chk(2'd0, 32'd3, "R12 mode reads sleep");
    @(negedge clk);
    if (src == 16) rtc_alarm = 1'b1; else ext_irq[src] = 1'b1;
    wait_neg(2);
    chk(!core_pwr_on, "R7 no wake before sync", {31'd0, core_pwr_on}, 32'd0);
    wait_neg(1);
    chk_vec("R8 wake edge: power on, reset held", 4);
    rd_chk(2'd0, 32'd4, "R12 mode reads waking");
    if (hold > 0) begin
      wait_neg(hold);
      chk_vec("R8 reset still held at last hold cycle", 4);
    end
    wait_neg(1);
    m_mode = 0; m_rs = 1'b0;
    chk_vec("R8 normal after hold", 0);
    rtc_alarm = 1'b0; ext_irq = '0;
    wait_neg(3);
    rd_chk(2'd2, 32'(1) << src, "R9 wake source recorded");
    wr(2'd2, ~(32'(1) << src));
    rd_chk(2'd2, 32'(1) << src, "R9 writing zero keeps bit");
    wr(2'd2, 32'(1) << src);
    rd_chk(2'd2, 32'd0, "R9 write one clears bit");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd7741);
    wait_neg(4);
    rst_n = 1'b1;
    wait_neg(1);

    // R1
    chk_vec("R1 reset outputs", 0);
    rd_chk(2'd0, 32'd0, "R1 mode reg");
    rd_chk(2'd1, 32'hFF, "R1 clock enable reg");
    rd_chk(2'd2, 32'd0, "R1 wake source reg");
    rd_chk(2'd3, 32'h8000_0004, "R1 config reg");

    // R2
    wr(2'd1, 32'hA5);
    chk(periph_clk_en === 8'hFF, "R2 not yet at first edge", {24'd0, periph_clk_en}, 32'hFF);
    wait_neg(1);
    m_ce = 8'hA5;
    chk_vec("R2 peripheral enables follow register", 0);

    // R11
    wr(2'd3, 32'h0000_0004);
    wait_neg(1);
    m_usb = 1'b0;
    chk_vec("R11 usb off in normal", 0);

    // R3 / R12
    req(1);
    chk_vec("R3 slow mode", 1);
    rd_chk(2'd0, 32'd1, "R12 mode reads slow");
    wr(2'd3, 32'h8000_0004);
    wait_neg(1);
    m_usb = 1'b1;
    chk_vec("R11 usb on in slow", 1);

    // R4 / R5 / R10 from slow
    req(2);
    chk_vec("R4 idle from slow keeps source", 2);
    rd_chk(2'd0, 32'd2, "R12 mode reads idle");
    @(negedge clk); ext_irq[3] = 1'b1; rtc_alarm = 1'b1;
    wait_neg(5);
    chk_vec("R5 external and RTC do not end idle", 2);
    ext_irq = '0; rtc_alarm = 1'b0;
    req(0);
    wait_neg(1);
    chk_vec("R10 request in idle ignored", 2);
    idle_exit("R5 slow");
    req(0);
    chk_vec("R3 back to normal", 0);
    req(2);
    chk_vec("R4 idle from normal", 2);
    idle_exit("R5 normal");

    // sleep: R7 cpu_irq ignored, R10 request ignored
    wr(2'd3, 32'h8000_0002);
    req(3);
    @(negedge clk); cpu_irq = 1'b1;
    wait_neg(5);
    chk_vec("R7 cpu_irq does not end sleep", 3);
    cpu_irq = 1'b0;
    req(0);
    wait_neg(1);
    chk_vec("R10 request in sleep ignored", 3);
    @(negedge clk); ext_irq[9] = 1'b1;
    wait_neg(3);
    chk_vec("R7 external line ends sleep", 4);
    wait_neg(2);
    chk_vec("R8 reset held through hold=2", 4);
    wait_neg(1);
    m_mode = 0; m_rs = 1'b0;
    chk_vec("R8 normal after hold=2", 0);
    ext_irq = '0;
    wait_neg(3);
    rd_chk(2'd2, 32'h200, "R9 line 9 recorded");
    wr(2'd2, 32'h200);

    sleep_cycle(16, 0);
    sleep_cycle(0, 5);
    sleep_cycle(15, 1);

    // random mix of enable writes and normal/slow/idle transitions
    for (int i = 0; i < 60; i++) begin
      int op;
      op = $urandom_range(0, 3);
      case (op)
        0: begin
          m_ce = 8'($urandom);
          wr(2'd1, {24'd0, m_ce});
          wait_neg(1);
          chk_vec("R2 random enable write", m_mode);
        end
        1: begin req(0); chk_vec("R3 random to normal", m_mode); end
        2: begin req(1); chk_vec("R3 random to slow", m_mode); end
        default: begin
          req(2);
          chk_vec("R4 random idle", m_mode);
          idle_exit("R5 random");
        end
      endcase
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule